// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the processor-facing register file of a four-channel DMA controller. A host reaches it one byte at a time through a 4-bit port offset with synchronous read and write strobes. For each channel it keeps a 16-bit address and a 16-bit count, each as a base copy and a current copy, plus a mode byte. It also keeps a command byte, a four-bit mask and a four-bit terminal-count status.

Every 16-bit value passes through an 8-bit port. One byte-order flip-flop is shared by all address and count registers, so software clears it first and then moves low byte, high byte. Mask changes, mode loads, flip-flop clear and master clear are encoded command writes at fixed offsets.

All register contents leave the block in parallel for a transfer engine. The engine returns single-cycle pulses that set status bits and mask bits.

Top module: `dmareg_top`

## Requirements
- R1: After reset every base and current address and count, every mode byte, the command byte, the mask, the status and the byte-order flip-flop read as zero.
- R2: A host access at an offset below 8 selects channel offset[2:1]. Offset bit 0 clear selects that channel's address register and bit 0 set selects its count register.
- R3: Every read or write at offsets 0 to 7 toggles the single shared byte-order flip-flop. When the flip-flop is clear the access carries the low byte, and when it is set the access carries the high byte.
- R4: A byte written to an address or count register replaces that byte of the base copy. The complete new base value is then loaded into the current copy in the same clock.
- R5: A read at offsets 0 to 7 returns the selected byte of the current copy.
- R6: A read at offset 8 returns the status nibble in bits 3:0, with zero in bits 7:4, and clears the status. Status bits set by the engine in that same cycle survive the clear.
- R7: A write at offset 8 loads the command byte.
- R8: A write at offset 0xA changes one mask bit, chosen by data bits 1:0. Data bit 2 set masks that channel and data bit 2 clear unmasks it.
- R9: A write at offset 0xB stores the whole data byte as the mode of the channel in data bits 1:0.
- R10: A write at offset 0xC clears the byte-order flip-flop. A write at offset 0xD clears the flip-flop and sets all four mask bits. A read at offset 0xD returns zero.
- R11: A write at offset 0xF loads the mask from data bits 3:0.
- R12: A read at offsets 9, 0xA, 0xB, 0xC, 0xE or 0xF returns the last byte written at that offset.
- R13: Engine status-set and mask-set pulses are ORed in on the same clock edge as any host access, after the host update has been applied.

If both strobes are high in one cycle, the write takes effect and the read has no side effect. When the read strobe is low, read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busOffset | input | 4 | Register offset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational during the read strobe |
| engStatusSet | input | 4 | Engine pulses that set status bits |
| engMaskSet | input | 4 | Engine pulses that set mask bits |
| chBaseAddr | output | 64 | Base addresses, channel n in bits 16n+15:16n |
| chCurAddr | output | 64 | Current addresses, same packing |
| chBaseCount | output | 64 | Base counts, same packing |
| chCurCount | output | 64 | Current counts, same packing |
| chMode | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| cmdReg | output | 8 | Command byte |
| maskReg | output | 4 | Channel mask |
| statusReg | output | 4 | Terminal-count status |

## Verification
The bench builds the block with the package defaults: four channels, 16-bit registers and byte-wide access. These are the only values the fixed offset decode supports, and they put every channel, both byte lanes and each command offset within reach. A behavioural model steps alongside the design and is compared on every clock. The stimulus covers byte-pointer states left unaligned by a stray read, engine pulses that coincide with status-clearing reads and with mask loads, and shadowed reads at the command offsets.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int NUM_CH   = 4;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int BYTE_W   = 8;
  localparam int REG_W    = 2 * BYTE_W;
  localparam int OFF_W    = 4;
  localparam int NUM_OFF  = 1 << OFF_W;

  localparam logic [OFF_W-1:0] OFF_STAT_CMD  = 4'h8;
  localparam logic [OFF_W-1:0] OFF_MASK_ONE  = 4'hA;
  localparam logic [OFF_W-1:0] OFF_MODE      = 4'hB;
  localparam logic [OFF_W-1:0] OFF_PTR_CLR   = 4'hC;
  localparam logic [OFF_W-1:0] OFF_MASTER    = 4'hD;
  localparam logic [OFF_W-1:0] OFF_MASK_ALL  = 4'hF;

  typedef enum logic [1:0] {
    RD_CHREG  = 2'd0,
    RD_STATUS = 2'd1,
    RD_ZERO   = 2'd2,
    RD_SHADOW = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CH-1:0] addrWr;
    logic [NUM_CH-1:0] cntWr;
    logic              hiByte;
    logic              cmdWr;
    logic              maskOneWr;
    logic              modeWr;
    logic              maskAllSet;
    logic              maskLoad;
    logic              statusClr;
    logic              shadowWr;
    rdSel_e            rdSel;
    logic              rdIsCount;
    logic [CH_W-1:0]   rdCh;
  } regStrobes_t;

  function automatic logic [REG_W-1:0] mergeByte(
    input logic [REG_W-1:0]  oldVal,
    input logic [BYTE_W-1:0] newByte,
    input logic              hiLane
  );
    logic [REG_W-1:0] res;
    res = oldVal;
    if (hiLane) res[REG_W-1:BYTE_W] = newByte;
    else        res[BYTE_W-1:0]     = newByte;
    return res;
  endfunction

endpackage

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
  import dmareg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] busOffset,
  input  logic             busWrEn,
  input  logic             busRdEn,
  output regStrobes_t      strobes,
  output logic             ptrHi
);

  logic            ptrQ;
  logic            ptrNext;
  logic            isChReg;
  logic            doWr;
  logic            doRd;
  logic [CH_W-1:0] selCh;

  assign isChReg = ~busOffset[OFF_W-1];
  assign selCh   = busOffset[CH_W:1];
  assign doWr    = busWrEn;
  assign doRd    = busRdEn & ~busWrEn;

  // decode of host strobes into datapath controls
  always_comb begin
    strobes           = '0;
    strobes.hiByte    = ptrQ;
    strobes.rdCh      = selCh;
    strobes.rdIsCount = busOffset[0];
    for (int i = 0; i < NUM_CH; i++) begin
      strobes.addrWr[i] = doWr & isChReg & ~busOffset[0] & (selCh == CH_W'(i));
      strobes.cntWr[i]  = doWr & isChReg &  busOffset[0] & (selCh == CH_W'(i));
    end
    strobes.cmdWr      = doWr & (busOffset == OFF_STAT_CMD);
    strobes.maskOneWr  = doWr & (busOffset == OFF_MASK_ONE);
    strobes.modeWr     = doWr & (busOffset == OFF_MODE);
    strobes.maskAllSet = doWr & (busOffset == OFF_MASTER);
    strobes.maskLoad   = doWr & (busOffset == OFF_MASK_ALL);
    strobes.statusClr  = doRd & (busOffset == OFF_STAT_CMD);
    strobes.shadowWr   = doWr;
    if (isChReg)                           strobes.rdSel = RD_CHREG;
    else if (busOffset == OFF_STAT_CMD)    strobes.rdSel = RD_STATUS;
    else if (busOffset == OFF_MASTER)      strobes.rdSel = RD_ZERO;
    else                                   strobes.rdSel = RD_SHADOW;
  end

  // shared byte-order flip-flop
  always_comb begin
    ptrNext = ptrQ;
    if (doWr && (busOffset == OFF_PTR_CLR || busOffset == OFF_MASTER))
      ptrNext = 1'b0;
    else if ((doWr || doRd) && isChReg)
      ptrNext = ~ptrQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptrQ <= 1'b0;
    else        ptrQ <= ptrNext;
  end

  assign ptrHi = ptrQ;

endmodule

// File: rtl/dmareg_datapath.sv
module dmareg_datapath
  import dmareg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  regStrobes_t              strobes,
  input  logic [OFF_W-1:0]         busOffset,
  input  logic                     busRdEn,
  input  logic [BYTE_W-1:0]        busWrData,
  output logic [BYTE_W-1:0]        busRdData,
  input  logic [NUM_CH-1:0]        engStatusSet,
  input  logic [NUM_CH-1:0]        engMaskSet,
  output logic [NUM_CH*REG_W-1:0]  chBaseAddr,
  output logic [NUM_CH*REG_W-1:0]  chCurAddr,
  output logic [NUM_CH*REG_W-1:0]  chBaseCount,
  output logic [NUM_CH*REG_W-1:0]  chCurCount,
  output logic [NUM_CH*BYTE_W-1:0] chMode,
  output logic [BYTE_W-1:0]        cmdReg,
  output logic [NUM_CH-1:0]        maskReg,
  output logic [NUM_CH-1:0]        statusReg
);

  logic [REG_W-1:0]  baseAddrQ [NUM_CH];
  logic [REG_W-1:0]  curAddrQ  [NUM_CH];
  logic [REG_W-1:0]  baseCntQ  [NUM_CH];
  logic [REG_W-1:0]  curCntQ   [NUM_CH];
  logic [BYTE_W-1:0] modeQ     [NUM_CH];
  logic [BYTE_W-1:0] shadowQ   [NUM_OFF];
  logic [BYTE_W-1:0] cmdQ;
  logic [NUM_CH-1:0] maskQ;
  logic [NUM_CH-1:0] maskNext;
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] statusNext;
  logic [CH_W-1:0]   modeCh;

  assign modeCh = busWrData[CH_W-1:0];

  // per-channel address, count and mode storage
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [REG_W-1:0] addrMerged;
    logic [REG_W-1:0] cntMerged;

    assign addrMerged = mergeByte(baseAddrQ[ch], busWrData, strobes.hiByte);
    assign cntMerged  = mergeByte(baseCntQ[ch],  busWrData, strobes.hiByte);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        baseAddrQ[ch] <= '0;
        curAddrQ[ch]  <= '0;
        baseCntQ[ch]  <= '0;
        curCntQ[ch]   <= '0;
        modeQ[ch]     <= '0;
      end else begin
        if (strobes.addrWr[ch]) begin
          baseAddrQ[ch] <= addrMerged;
          curAddrQ[ch]  <= addrMerged;
        end
        if (strobes.cntWr[ch]) begin
          baseCntQ[ch] <= cntMerged;
          curCntQ[ch]  <= cntMerged;
        end
        if (strobes.modeWr && modeCh == CH_W'(ch))
          modeQ[ch] <= busWrData;
      end
    end

    assign chBaseAddr [ch*REG_W +: REG_W]   = baseAddrQ[ch];
    assign chCurAddr  [ch*REG_W +: REG_W]   = curAddrQ[ch];
    assign chBaseCount[ch*REG_W +: REG_W]   = baseCntQ[ch];
    assign chCurCount [ch*REG_W +: REG_W]   = curCntQ[ch];
    assign chMode     [ch*BYTE_W +: BYTE_W] = modeQ[ch];
  end

  // mask: host command first, then engine pulses
  always_comb begin
    maskNext = maskQ;
    if (strobes.maskOneWr)
      maskNext[modeCh] = busWrData[2];
    if (strobes.maskAllSet)
      maskNext = '1;
    if (strobes.maskLoad)
      maskNext = busWrData[NUM_CH-1:0];
    maskNext = maskNext | engMaskSet;
  end

  // status: read clears, engine pulses stick
  always_comb begin
    statusNext = strobes.statusClr ? '0 : statusQ;
    statusNext = statusNext | engStatusSet;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdQ    <= '0;
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      if (strobes.cmdWr) cmdQ <= busWrData;
      maskQ   <= maskNext;
      statusQ <= statusNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_OFF; k++) shadowQ[k] <= '0;
    end else if (strobes.shadowWr) begin
      shadowQ[busOffset] <= busWrData;
    end
  end

  // read multiplexer
  logic [REG_W-1:0]  chWord;
  logic [BYTE_W-1:0] rdByte;

  always_comb begin
    chWord = strobes.rdIsCount ? curCntQ[strobes.rdCh] : curAddrQ[strobes.rdCh];
    unique case (strobes.rdSel)
      RD_CHREG:  rdByte = strobes.hiByte ? chWord[REG_W-1:BYTE_W] : chWord[BYTE_W-1:0];
      RD_STATUS: rdByte = {{(BYTE_W-NUM_CH){1'b0}}, statusQ};
      RD_ZERO:   rdByte = '0;
      default:   rdByte = shadowQ[busOffset];
    endcase
  end

  assign busRdData = busRdEn ? rdByte : '0;
  assign cmdReg    = cmdQ;
  assign maskReg   = maskQ;
  assign statusReg = statusQ;

endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
  import dmareg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [OFF_W-1:0]         busOffset,
  input  logic                     busWrEn,
  input  logic                     busRdEn,
  input  logic [BYTE_W-1:0]        busWrData,
  output logic [BYTE_W-1:0]        busRdData,
  input  logic [NUM_CH-1:0]        engStatusSet,
  input  logic [NUM_CH-1:0]        engMaskSet,
  output logic [NUM_CH*REG_W-1:0]  chBaseAddr,
  output logic [NUM_CH*REG_W-1:0]  chCurAddr,
  output logic [NUM_CH*REG_W-1:0]  chBaseCount,
  output logic [NUM_CH*REG_W-1:0]  chCurCount,
  output logic [NUM_CH*BYTE_W-1:0] chMode,
  output logic [BYTE_W-1:0]        cmdReg,
  output logic [NUM_CH-1:0]        maskReg,
  output logic [NUM_CH-1:0]        statusReg
);

  regStrobes_t strobes;
  logic        ptrHi;

  dmareg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busOffset (busOffset),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .strobes   (strobes),
    .ptrHi     (ptrHi)
  );

  dmareg_datapath u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .busOffset    (busOffset),
    .busRdEn      (busRdEn),
    .busWrData    (busWrData),
    .busRdData    (busRdData),
    .engStatusSet (engStatusSet),
    .engMaskSet   (engMaskSet),
    .chBaseAddr   (chBaseAddr),
    .chCurAddr    (chCurAddr),
    .chBaseCount  (chBaseCount),
    .chCurCount   (chCurCount),
    .chMode       (chMode),
    .cmdReg       (cmdReg),
    .maskReg      (maskReg),
    .statusReg    (statusReg)
  );

endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk
  import dmareg_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic [OFF_W-1:0]         busOffset,
  input logic                     busWrEn,
  input logic                     busRdEn,
  input logic [BYTE_W-1:0]        busWrData,
  input logic [BYTE_W-1:0]        busRdData,
  input logic [NUM_CH-1:0]        engStatusSet,
  input logic [NUM_CH-1:0]        engMaskSet,
  input logic [NUM_CH*BYTE_W-1:0] chMode,
  input logic [BYTE_W-1:0]        cmdReg,
  input logic [NUM_CH-1:0]        maskReg,
  input logic [NUM_CH-1:0]        statusReg,
  input logic                     ptrHi
);

  logic hostRd;
  assign hostRd = busRdEn & ~busWrEn;

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((busWrEn || busRdEn) && !busOffset[OFF_W-1]) |=> (ptrHi != $past(ptrHi))); // R3

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRd && busOffset == OFF_STAT_CMD) |-> (busRdData == {{(BYTE_W-NUM_CH){1'b0}}, statusReg})); // R6

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRd && busOffset == OFF_STAT_CMD && engStatusSet == '0) |=> (statusReg == '0)); // R6

  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busOffset == OFF_STAT_CMD) |=> (cmdReg == $past(busWrData))); // R7

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busOffset == OFF_MODE) |=>
      (chMode[int'($past(busWrData[CH_W-1:0]))*BYTE_W +: BYTE_W] == $past(busWrData))); // R9

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busOffset == OFF_PTR_CLR) |=> !ptrHi); // R10

  AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busOffset == OFF_MASTER) |=> (maskReg == '1 && !ptrHi)); // R10

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (hostRd && busOffset == OFF_MASTER) |-> (busRdData == '0)); // R10

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (engStatusSet != '0) |=> ((statusReg & $past(engStatusSet)) == $past(engStatusSet))); // R13

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (engMaskSet != '0) |=> ((maskReg & $past(engMaskSet)) == $past(engMaskSet))); // R13

endmodule

bind dmareg_top dmareg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busOffset    (busOffset),
  .busWrEn      (busWrEn),
  .busRdEn      (busRdEn),
  .busWrData    (busWrData),
  .busRdData    (busRdData),
  .engStatusSet (engStatusSet),
  .engMaskSet   (engMaskSet),
  .chMode       (chMode),
  .cmdReg       (cmdReg),
  .maskReg      (maskReg),
  .statusReg    (statusReg),
  .ptrHi        (ptrHi)
);

// File: tb/sim_dmareg_top.sv
`timescale 1ns/1ps
module sim_dmareg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busOffset = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [3:0]  engStatusSet = '0;
  logic [3:0]  engMaskSet = '0;
  logic [63:0] chBaseAddr, chCurAddr, chBaseCount, chCurCount;
  logic [31:0] chMode;
  logic [7:0]  cmdReg;
  logic [3:0]  maskReg, statusReg;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  int mBaseA[4], mCurA[4], mBaseC[4], mCurC[4], mMode[4];
  int mShadow[16];
  int mCmd, mMask, mStat, mPtr;

  always #2 clk = ~clk;

  dmareg_top u0 (
    .clk(clk), .rst_n(rst_n), .busOffset(busOffset), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .engStatusSet(engStatusSet), .engMaskSet(engMaskSet),
    .chBaseAddr(chBaseAddr), .chCurAddr(chCurAddr), .chBaseCount(chBaseCount),
    .chCurCount(chCurCount), .chMode(chMode), .cmdReg(cmdReg),
    .maskReg(maskReg), .statusReg(statusReg)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int modelRead(input int off);
    int v;
    if (off < 8) begin
      v = (off & 1) ? mCurC[off >> 1] : mCurA[off >> 1];
      return mPtr ? ((v >> 8) & 255) : (v & 255);
    end
    if (off == 8)  return mStat;
    if (off == 13) return 0;
    return mShadow[off];
  endfunction

  task automatic compareAll(input string tag);
    for (int c = 0; c < 4; c++) begin
      check(tag, "baseAddr", int'(chBaseAddr[c*16 +: 16]), mBaseA[c]);
      check(tag, "curAddr",  int'(chCurAddr[c*16 +: 16]),  mCurA[c]);
      check(tag, "baseCnt",  int'(chBaseCount[c*16 +: 16]), mBaseC[c]);
      check(tag, "curCnt",   int'(chCurCount[c*16 +: 16]), mCurC[c]);
      check(tag, "mode",     int'(chMode[c*8 +: 8]),       mMode[c]);
    end
    check(tag, "cmd",    int'(cmdReg),    mCmd);
    check(tag, "mask",   int'(maskReg),   mMask);
    check(tag, "status", int'(statusReg), mStat);
  endtask

  // one clock: drive, check read data before the edge, update model, compare after
  task automatic op(input string tag, input bit wr, input bit rd, input int off,
                    input int d, input int sset, input int mset);
    int v;
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busOffset = 4'(off); busWrData = 8'(d);
    engStatusSet = 4'(sset); engMaskSet = 4'(mset);
    #1;
    if (rd) check(tag, "rdData", int'(busRdData), wr ? modelRead(off) : modelRead(off));
    else    check(tag, "rdIdle", int'(busRdData), 0);
    @(posedge clk);
    #1;
    if (wr) begin
      mShadow[off] = d;
      if (off < 8) begin
        v = (off & 1) ? mBaseC[off >> 1] : mBaseA[off >> 1];
        v = mPtr ? ((v & 255) | (d << 8)) : ((v & 16'hff00) | d);
        if (off & 1) begin mBaseC[off >> 1] = v; mCurC[off >> 1] = v; end
        else         begin mBaseA[off >> 1] = v; mCurA[off >> 1] = v; end
        mPtr ^= 1;
      end else if (off == 8)  mCmd = d;
      else if (off == 10) begin
        if (d & 4) mMask |= (1 << (d & 3));
        else       mMask &= ~(1 << (d & 3)) & 15;
      end
      else if (off == 11) mMode[d & 3] = d;
      else if (off == 12) mPtr = 0;
      else if (off == 13) begin mPtr = 0; mMask = 15; end
      else if (off == 15) mMask = d & 15;
    end else if (rd) begin
      if (off < 8) mPtr ^= 1;
      if (off == 8) mStat = 0;
    end
    mStat |= sset;
    mMask |= mset;
    busWrEn = 0; busRdEn = 0; engStatusSet = 0; engMaskSet = 0;
    compareAll(tag);
  endtask

  task automatic wr(input string tag, input int off, input int d);
    op(tag, 1, 0, off, d, 0, 0);
  endtask

  task automatic rd(input string tag, input int off);
    op(tag, 0, 1, off, 0, 0, 0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mBaseA[i] = 0; mCurA[i] = 0; mBaseC[i] = 0; mCurC[i] = 0; mMode[i] = 0;
    end
    for (int i = 0; i < 16; i++) mShadow[i] = 0;
    mCmd = 0; mMask = 0; mStat = 0; mPtr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 compareAll("R1");
    rd("R1", 0);                     // low byte of zeroed register, ptr now set
    wr("R10", 12, 0);                // clear pointer

    // R2 R4: address and count of several channels, low then high
    wr("R2", 4, 8'h34);  wr("R4", 4, 8'h12);
    wr("R2", 3, 8'hcd);  wr("R4", 3, 8'hab);
    wr("R2", 0, 8'h01);  wr("R4", 0, 8'h80);
    wr("R2", 7, 8'hff);  wr("R4", 7, 8'hff);
    // R5: read back current values
    rd("R5", 4); rd("R5", 4);
    rd("R5", 3); rd("R5", 3);
    // R3: a stray read leaves the pointer on the high lane
    rd("R3", 6);
    wr("R3", 2, 8'h77);              // lands in high byte of channel 1 address
    wr("R3", 2, 8'h55);              // low byte
    rd("R3", 2); rd("R3", 2);
    // R10: clear mid-sequence then reload
    wr("R3", 5, 8'h99);
    wr("R10", 12, 8'h00);
    wr("R4", 5, 8'h11); wr("R4", 5, 8'h22);
    // R7 command, R9 modes
    wr("R7", 8, 8'ha5);
    wr("R9", 11, 8'h5a); wr("R9", 11, 8'h97); wr("R9", 11, 8'h44);
    // R8 single mask bits
    wr("R8", 10, 8'h06); wr("R8", 10, 8'h05); wr("R8", 10, 8'h02);
    // R11 mask load, R13 with simultaneous engine mask pulse
    wr("R11", 15, 8'hf9);
    op("R13", 1, 0, 15, 8'h00, 0, 4'h4);
    // R10 master clear and zero read
    wr("R3", 1, 8'h10);              // pointer now set
    wr("R10", 13, 8'h00);
    rd("R10", 13);
    wr("R10", 1, 8'h33);             // low lane after master clear
    // R6 R13 status: engine sets, read clears, coincident set survives
    op("R13", 0, 0, 0, 0, 4'h5, 0);
    rd("R6", 8);
    op("R13", 0, 0, 0, 0, 4'h3, 0);
    op("R6", 0, 1, 8, 0, 4'h8, 0);
    rd("R6", 8);
    rd("R6", 8);
    // R12 shadow reads
    wr("R12", 9, 8'h3c); wr("R12", 14, 8'hc3);
    rd("R12", 9); rd("R12", 14); rd("R12", 10); rd("R12", 11);
    rd("R12", 15); rd("R12", 12);
    // write and read together: write wins
    op("R6", 1, 1, 8, 8'h5e, 0, 0);
    repeat (2) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule